// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block turns a free-running reference clock into a sparse stream of single-cycle enable strobes whose average rate is a rational fraction of the reference. Two stages set the rate. A half-step pre-divider comes first. It is followed by an M/N accumulator that lets through M out of every N pre-divided strobes. The block also drives a duty-shaped level that is high while the accumulator sits below a programmable threshold.

The configuration comes from a register bank that holds its fields in compact encodings. The pre-divider field `v` is written as twice the division minus one. The reference is taken to run at twice the rate of the output unit, so the pre-divided strobe arrives once every `v+1` reference cycles. The N field holds the bitwise complement of N−M, and the threshold field holds the bitwise complement of the threshold. A one-cycle `load` pulse restarts every counter from zero, so that new settings take effect from a known phase. The block has no data stream, so its pins are plain control and status pins with no handshake.

Top module: `frac_clken_gen`

## Requirements
- R1: While `rst_n` is low, `en_o` and `duty_o` are 0, and all counters and the accumulator are 0.
- R2: The pre-divider counts reference cycles from 0. It emits a strobe in every cycle whose count is at least `div_cfg`, and the count returns to 0 after that strobe. As a result, `div_cfg` = v ≥ 1 gives one strobe every v+1 cycles, and v = 0 gives a strobe on every cycle.
- R3: The divisor is decoded as N = (~`n_inv_cfg` + `m_cfg`) modulo 2^MND_W, and the threshold as D = ~`d_inv_cfg` modulo 2^MND_W.
- R4: The fractional stage is active when `mode_cfg` equals 2'b10, N ≠ 0 and M ≠ N (M < N is the supported range). On each pre-divided strobe it adds M to the accumulator. If the sum is N or more, it pulses `en_o` and keeps the sum minus N. Otherwise it keeps the sum and `en_o` stays low. Starting from a load, this gives M enables in every N pre-divided strobes.
- R5: When the fractional stage is not active (any other mode, N = 0, or M = N), `en_o` copies the pre-divided strobe and the accumulator stays at 0.
- R6: In active mode, `duty_o` is 1 exactly when the updated accumulator is below D. In bypass, `duty_o` equals `en_o`.
- R7: A cycle with `load` high clears the pre-divider count, the accumulator and both outputs at that edge. After a load with v ≥ 1, the first pre-divided strobe comes at the (v+1)th following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Synchronous restart of all counters |
| div_cfg | input | HID_W | Half-step pre-divider field (2×div−1, 0 = bypass) |
| mode_cfg | input | 2 | Mode field, 2'b10 selects the fractional stage |
| m_cfg | input | MND_W | Numerator M |
| n_inv_cfg | input | MND_W | Complement of N−M |
| d_inv_cfg | input | MND_W | Complement of the duty threshold |
| en_o | output | 1 | Clock-enable strobe |
| duty_o | output | 1 | Duty-shaped level |

## Verification
Both outputs are registered. They take the value computed from the inputs and state present at a rising edge, and hold it until the next edge. A load therefore shows as zeros one edge later, and a changed divide field shows after v+1 edges. The bench drives inputs on falling edges and steps its reference model on the same rising edge that the design uses. It compares both outputs at the following falling edge, on every cycle. Rate checks count enables over whole windows that start at a load. The expected counts are floor(K·M/N) for the fractional stage and K/(v+1) for the pre-divider.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam logic [1:0] MODE_FRAC = 2'b10;
endpackage

// File: rtl/frac_cfg_decode.sv
module frac_cfg_decode #(
  parameter int MND_W = 8
) (
  input  logic [1:0]       mode_cfg,
  input  logic [MND_W-1:0] m_cfg,
  input  logic [MND_W-1:0] n_inv_cfg,
  input  logic [MND_W-1:0] d_inv_cfg,
  output logic [MND_W-1:0] n_val,
  output logic [MND_W-1:0] d_val,
  output logic             frac_on
);
  import frac_clk_pkg::*;

  // R3: recover N from the complemented difference, D from its complement
  always_comb begin
    n_val   = (~n_inv_cfg) + m_cfg;
    d_val   = ~d_inv_cfg;
    frac_on = (mode_cfg == MODE_FRAC) && (n_val != '0) && (m_cfg != n_val);
  end
endmodule

// File: rtl/frac_predivider.sv
module frac_predivider #(
  parameter int HID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HID_W-1:0] div_cfg,
  output logic             pd_stb
);
  logic [HID_W-1:0] cnt_q;

  assign pd_stb = !load && (cnt_q >= div_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= '0;
    else if (pd_stb) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R7
  load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));

  // R2
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_stb && div_cfg != '0) |=> (!pd_stb || div_cfg == '0));
endmodule

// File: rtl/frac_mn_accum.sv
module frac_mn_accum #(
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             pd_stb,
  input  logic             frac_on,
  input  logic [MND_W-1:0] m_val,
  input  logic [MND_W-1:0] n_val,
  input  logic [MND_W-1:0] d_val,
  output logic             en_o,
  output logic             duty_o
);
  localparam int SUM_W = MND_W + 1;

  logic [MND_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic             wrap, en_d, duty_d;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, m_val};
    wrap   = sum >= {1'b0, n_val};
    acc_d  = acc_q;
    en_d   = 1'b0;
    duty_d = 1'b0;
    if (frac_on) begin
      if (pd_stb) begin
        en_d  = wrap;
        acc_d = wrap ? MND_W'(sum - {1'b0, n_val}) : sum[MND_W-1:0];
      end
      duty_d = acc_d < d_val;
    end else begin
      acc_d  = '0;
      en_d   = pd_stb;
      duty_d = pd_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      en_o   <= 1'b0;
      duty_o <= 1'b0;
    end else if (load) begin
      acc_q  <= '0;
      en_o   <= 1'b0;
      duty_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      en_o   <= en_d;
      duty_o <= duty_d;
    end
  end

  // R4
  en_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> $past(pd_stb));

  // R5
  bypass_acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!frac_on) |-> (acc_q == '0));
endmodule

// File: rtl/frac_clken_gen.sv
module frac_clken_gen #(
  parameter int HID_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HID_W-1:0] div_cfg,
  input  logic [1:0]       mode_cfg,
  input  logic [MND_W-1:0] m_cfg,
  input  logic [MND_W-1:0] n_inv_cfg,
  input  logic [MND_W-1:0] d_inv_cfg,
  output logic             en_o,
  output logic             duty_o
);
  logic             pd_stb;
  logic             frac_on;
  logic [MND_W-1:0] n_val, d_val;

  frac_cfg_decode #(.MND_W(MND_W)) u_dec (
    .mode_cfg (mode_cfg),
    .m_cfg    (m_cfg),
    .n_inv_cfg(n_inv_cfg),
    .d_inv_cfg(d_inv_cfg),
    .n_val    (n_val),
    .d_val    (d_val),
    .frac_on  (frac_on)
  );

  frac_predivider #(.HID_W(HID_W)) u_pd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .div_cfg(div_cfg),
    .pd_stb (pd_stb)
  );

  frac_mn_accum #(.MND_W(MND_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .pd_stb (pd_stb),
    .frac_on(frac_on),
    .m_val  (m_cfg),
    .n_val  (n_val),
    .d_val  (d_val),
    .en_o   (en_o),
    .duty_o (duty_o)
  );

  // R7
  load_quiets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!en_o && !duty_o));

  // R6
  bypass_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!frac_on) |-> (duty_o == en_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!en_o && !duty_o));
endmodule

// File: tb/sim_frac_clken_gen.sv
`timescale 1ns/1ps
module sim_frac_clken_gen;
  localparam int HW = 5;
  localparam int MW = 8;
  localparam int MASK = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic load = 1'b0;
  logic [HW-1:0] div_cfg = '0;
  logic [1:0] mode_cfg = '0;
  logic [MW-1:0] m_cfg = '0, n_inv_cfg = '0, d_inv_cfg = '0;
  logic en_o, duty_o;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit armed = 0, done = 0;

  // model state
  int m_cnt = 0, m_acc = 0;
  bit m_en = 0, m_duty = 0;

  always #2.5 clk = ~clk;

  frac_clken_gen #(.HID_W(HW), .MND_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .div_cfg(div_cfg),
    .mode_cfg(mode_cfg), .m_cfg(m_cfg), .n_inv_cfg(n_inv_cfg),
    .d_inv_cfg(d_inv_cfg), .en_o(en_o), .duty_o(duty_o));

  always @(posedge clk) begin
    int n, d, sum;
    bit stb, on;
    if (!rst_n || load) begin
      m_cnt = 0; m_acc = 0; m_en = 0; m_duty = 0;
      armed = 1;
    end else begin
      stb = (m_cnt >= int'(div_cfg));
      m_cnt = stb ? 0 : m_cnt + 1;
      n = (int'(~n_inv_cfg) + int'(m_cfg)) & MASK;
      d = int'(~d_inv_cfg) & MASK;
      on = (mode_cfg == 2'b10) && (n != 0) && (int'(m_cfg) != n);
      if (on) begin
        m_en = 0;
        if (stb) begin
          sum = m_acc + int'(m_cfg);
          if (sum >= n) begin m_en = 1; m_acc = (sum - n) & MASK; end
          else m_acc = sum;
        end
        m_duty = (m_acc < d);
      end else begin
        m_acc = 0; m_en = stb; m_duty = stb;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      compared++;
      if (en_o !== m_en || duty_o !== m_duty) begin
        mismatched++;
        $display("FAIL %s: en/duty actual %b%b expected %b%b at %0t",
                 tag, en_o, duty_o, m_en, m_duty, $time);
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic count_en(input int k, output int c);
    c = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      if (en_o) c++;
    end
  endtask

  task automatic setup(input int v, input int mode, input int m, input int n,
                       input int d);
    @(negedge clk);
    div_cfg = HW'(v); mode_cfg = 2'(mode); m_cfg = MW'(m);
    n_inv_cfg = MW'(~(n - m)); d_inv_cfg = MW'(~d);
  endtask

  initial begin
    int c;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 en in reset", int'(en_o), 0);
    check("R1 duty in reset", int'(duty_o), 0);
    rst_n = 1'b1;

    // R2, R5: full bypass
    tag = "R2"; setup(0, 0, 0, 0, 0); pulse_load();
    count_en(20, c); check("R2 v=0 strobes", c, 20);
    tag = "R2"; setup(3, 0, 0, 0, 0); pulse_load();
    count_en(40, c); check("R2 v=3 strobes", c, 10);
    setup(6, 0, 0, 0, 0); pulse_load();
    count_en(70, c); check("R2 v=6 strobes", c, 10);

    // R3, R4, R6: fractional stage 3/8, D=4
    tag = "R4"; setup(0, 2, 3, 8, 4); pulse_load();
    count_en(80, c); check("R4 3/8 enables", c, 30);
    tag = "R6"; setup(0, 2, 3, 8, 2);
    repeat (30) @(negedge clk);
    tag = "R3"; setup(2, 2, 5, 13, 7); pulse_load();
    count_en(39 * 3, c); check("R3 5/13 v=2 enables", c, 15);
    setup(1, 2, 1, 200, 100); pulse_load();
    count_en(400, c); check("R4 1/200 v=1 enables", c, 1);

    // R5: bypass cases
    tag = "R5"; setup(0, 2, 5, 5, 3); pulse_load();
    count_en(15, c); check("R5 M==N passes", c, 15);
    setup(1, 1, 3, 8, 4); pulse_load();
    count_en(16, c); check("R5 mode!=frac passes", c, 8);
    setup(0, 2, 0, 0, 0); pulse_load();
    count_en(12, c); check("R5 N==0 passes", c, 12);

    // R7: load mid-run
    tag = "R7"; setup(0, 2, 7, 9, 5);
    repeat (13) @(negedge clk);
    load = 1'b1; @(negedge clk); load = 1'b0;
    check("R7 en after load", int'(en_o), 0);
    check("R7 duty after load", int'(duty_o), 0);
    setup(4, 0, 0, 0, 0); pulse_load();
    count_en(4, c); check("R7 no strobe before v+1", c, 0);
    count_en(1, c); check("R7 strobe at v+1", c, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule